// File: doc/BRIEF.md
# Four-Channel Power Sourcing Mode Controller

This block manages four power-sourcing channels. Each channel has its own operating mode: off, manual, semi-automatic or automatic. Each channel also keeps a detection enable, a classification enable, a power-enable bit and a power-good bit. The block requests detection and classification cycles from external measurement logic, which is stubbed here as done/result inputs. It decides when a channel is powered. When a channel is switched off, the block wipes that channel's state. When power drops, it raises sticky power-event flags.

A host reaches the block through a single-cycle register write port and a combinational read port. A channel that loses power through a fault while in semi-automatic mode enters a cooldown. During the cooldown, new detection on that channel is held back.

Top module: `pse_mode_ctrl`

## Requirements
- R1: The mode register (address 0) resets to 0x00 and holds one 2-bit field per channel, with channel 0 in bits 1:0 and channel 3 in bits 7:6. The field codes are 00 off, 01 manual, 10 semi-automatic and 11 automatic.
- R2: After reset, the enables (address 1), events (address 3) and status (address 4) read 0x00, every policing byte (addresses 10..13) reads 0xFF, and no request or power output is asserted.
- R3: A channel in off mode never raises det_req, cls_req or pwr_en. Writes to its enable bits (address 1: bit i detect, bit 4+i class) and power-on writes to it (address 2, bit i) leave it unchanged.
- R4: The edge that writes a channel's field from a non-off code to 00 clears several items of that channel: its enables, power-enable, power-good, fault bit (address 5, bit i) and result byte. The same edge sets its policing byte to 0xFF. Other channels keep their state.
- R5: A 1-to-0 change of power-enable sets event bit i, and a 1-to-0 change of power-good sets event bit 4+i. Writing 1 to an event bit clears it. A new event on the same edge as a clear leaves the bit set.
- R6: In manual mode, a set detect enable produces exactly one detection request. A set class enable produces exactly one classification request, which follows the detection when both are set. Each enable clears itself when its cycle completes. No power-on happens automatically.
- R7: Writing 1 to bit i of address 2 powers a non-off channel on the write edge. Power-good follows one edge later while pg_in is high.
- R8: In semi-automatic mode, an unpowered channel repeats detection while its detect enable is set. It adds classification after each valid detection when both enables are set. With class enable alone, the channel stays idle. It never powers on by itself.
- R9: In automatic mode, a channel stays idle unless both enables are set. It repeats detection after an invalid signature. It powers on at the edge that completes classification after a valid detection.
- R10: pwr_fault on a powered channel clears its power-enable and sets its fault bit.
- R11: A fault that removes power from a semi-automatic channel loads a cooldown of COOL_CYCLES edges. Detection may restart no earlier than COOL_CYCLES+1 edges after the fault edge.
- R12: Moving a channel out of semi-automatic mode cancels its cooldown at once.
- R13: Result byte i (address 6+i) holds bit 0 = last detection valid, bits 3:1 = last class code and bit 4 = class reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational |
| det_done | input | 4 | Detection finished, one per channel |
| det_ok | input | 4 | Detection signature valid, sampled with det_done |
| cls_done | input | 4 | Classification finished, one per channel |
| cls_code | input | 12 | 3-bit class code per channel, channel i at bits 3i+2:3i |
| pg_in | input | 4 | Power-good sense per channel |
| pwr_fault | input | 4 | Fault strobe per channel |
| det_req | output | 4 | Detection cycle in progress |
| cls_req | output | 4 | Classification cycle in progress |
| pwr_en | output | 4 | Channel power enable |

## Verification
Register writes, off-entry clearing, power-on commands, fault drops and event flags all take effect on the write or strobe edge, so they show at the read port in the following low phase. A request rises one edge after the write or completion that enables it. Power-good lags power-enable by one edge. The end of a cooldown shows COOL_CYCLES+1 edges after the fault. The driver aligns every stimulus to a falling edge and counts edges explicitly before it queues an expected value, so each comparison lands on the first low phase where the result is due. Around the cooldown, the checks are placed one edge before and at the due edge.

// File: rtl/pse_mode_ctrl.sv
module pse_mode_ctrl #(
  parameter int COOL_CYCLES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [3:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic [3:0]  det_done,
  input  logic [3:0]  det_ok,
  input  logic [3:0]  cls_done,
  input  logic [11:0] cls_code,
  input  logic [3:0]  pg_in,
  input  logic [3:0]  pwr_fault,
  output logic [3:0]  det_req,
  output logic [3:0]  cls_req,
  output logic [3:0]  pwr_en
);
  localparam int NCH = 4;
  localparam int CW  = $clog2(COOL_CYCLES + 1);
  localparam logic [1:0] M_OFF = 2'b00, M_MAN = 2'b01, M_SEMI = 2'b10, M_AUTO = 2'b11;
  localparam logic [3:0] A_MODE = 4'd0, A_EN = 4'd1, A_PON = 4'd2, A_EVT = 4'd3;
  localparam logic [3:0] A_STAT = 4'd4, A_FLT = 4'd5, A_POL = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_DET, S_CLS} seq_t;

  logic [7:0] mode_q, mode_d;
  logic [3:0] de_q, de_d, ce_q, ce_d, pe_q, pe_d, pg_q, pg_d;
  logic [3:0] flt_q, flt_d, pev_q, pev_d, gev_q, gev_d;
  seq_t       st_q [NCH];
  seq_t       st_d [NCH];
  logic [CW-1:0] cool_q [NCH];
  logic [CW-1:0] cool_d [NCH];
  logic [7:0] res_q [NCH];
  logic [7:0] res_d [NCH];
  logic [7:0] pol_q [NCH];
  logic [7:0] pol_d [NCH];
  logic [1:0] cm [NCH];
  logic [1:0] nm [NCH];
  logic [3:0] chg, off_ent, drop;

  wire wr_mode = wr_en && (wr_addr == A_MODE);
  wire wr_ena  = wr_en && (wr_addr == A_EN);
  wire wr_pon  = wr_en && (wr_addr == A_PON);
  wire wr_evt  = wr_en && (wr_addr == A_EVT);

  assign mode_d = wr_mode ? wr_data : mode_q;
  assign pwr_en = pe_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign cm[g]      = mode_q[2*g +: 2];
    assign nm[g]      = mode_d[2*g +: 2];
    assign chg[g]     = cm[g] != nm[g];
    assign off_ent[g] = chg[g] && (nm[g] == M_OFF);
    assign det_req[g] = st_q[g] == S_DET;
    assign cls_req[g] = st_q[g] == S_CLS;

    a_r3_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cm[g] == M_OFF) |-> (!pe_q[g] && !de_q[g] && !ce_q[g] && st_q[g] == S_IDLE));
    a_r4_off_wipe: assert property (@(posedge clk) disable iff (!rst_n)
      off_ent[g] |=> (pol_q[g] == 8'hFF && res_q[g] == 8'h00 && !flt_q[g]));
    a_r5_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pe_q[g]) |-> pev_q[g]);
    a_r6_manual_once: assert property (@(posedge clk) disable iff (!rst_n)
      (cm[g] == M_MAN && st_q[g] == S_DET && det_done[g]) |=> !de_q[g]);
    a_r11_cool_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (cool_q[g] != '0) |-> (st_q[g] != S_DET));
  end

  always_comb begin
    de_d  = wr_ena ? wr_data[3:0] : de_q;
    ce_d  = wr_ena ? wr_data[7:4] : ce_q;
    pe_d  = pe_q;
    flt_d = flt_q;
    drop  = '0;
    for (int i = 0; i < NCH; i++) begin
      st_d[i]   = st_q[i];
      res_d[i]  = res_q[i];
      pol_d[i]  = (wr_en && wr_addr == A_POL + 4'(i)) ? wr_data : pol_q[i];
      cool_d[i] = (cool_q[i] != '0) ? cool_q[i] - CW'(1) : cool_q[i];
      case (st_q[i])
        S_IDLE: if (!pe_q[i]) begin
          if (cm[i] == M_MAN) begin
            if (de_q[i]) st_d[i] = S_DET;
            else if (ce_q[i]) st_d[i] = S_CLS;
          end else if ((cm[i] == M_SEMI || (cm[i] == M_AUTO && ce_q[i])) &&
                       de_q[i] && cool_q[i] == '0) begin
            st_d[i] = S_DET;
          end
        end
        S_DET: if (det_done[i]) begin
          res_d[i][0] = det_ok[i];
          if (cm[i] == M_MAN) begin
            de_d[i] = 1'b0;
            st_d[i] = ce_q[i] ? S_CLS : S_IDLE;
          end else if (det_ok[i] && de_q[i] && ce_q[i]) begin
            st_d[i] = S_CLS;
          end else begin
            st_d[i] = S_IDLE;
          end
        end
        S_CLS: if (cls_done[i]) begin
          res_d[i][4:1] = {1'b1, cls_code[3*i +: 3]};
          if (cm[i] == M_MAN) ce_d[i] = 1'b0;
          if (cm[i] == M_AUTO) pe_d[i] = 1'b1;
          st_d[i] = S_IDLE;
        end
        default: st_d[i] = S_IDLE;
      endcase
      if (wr_pon && wr_data[i] && cm[i] != M_OFF) pe_d[i] = 1'b1;
      if (pwr_fault[i] && pe_q[i]) begin
        pe_d[i]  = 1'b0;
        flt_d[i] = 1'b1;
        drop[i]  = 1'b1;
      end
      if (drop[i] && cm[i] == M_SEMI) cool_d[i] = CW'(COOL_CYCLES);
      if (chg[i]) begin
        st_d[i] = S_IDLE;
        if (cm[i] == M_SEMI) cool_d[i] = '0;
      end
      if (pe_d[i]) st_d[i] = S_IDLE;
      if (nm[i] == M_OFF) begin
        de_d[i] = 1'b0;
        ce_d[i] = 1'b0;
        pe_d[i] = 1'b0;
        st_d[i] = S_IDLE;
      end
      if (off_ent[i]) begin
        res_d[i] = 8'h00;
        flt_d[i] = 1'b0;
        pol_d[i] = 8'hFF;
      end
    end
  end

  assign pg_d  = pe_d & pe_q & pg_in;
  assign pev_d = (pev_q & ~(wr_evt ? wr_data[3:0] : 4'h0)) | (pe_q & ~pe_d);
  assign gev_d = (gev_q & ~(wr_evt ? wr_data[7:4] : 4'h0)) | (pg_q & ~pg_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      de_q   <= '0;
      ce_q   <= '0;
      pe_q   <= '0;
      pg_q   <= '0;
      flt_q  <= '0;
      pev_q  <= '0;
      gev_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        st_q[i]   <= S_IDLE;
        cool_q[i] <= '0;
        res_q[i]  <= '0;
        pol_q[i]  <= 8'hFF;
      end
    end else begin
      mode_q <= mode_d;
      de_q   <= de_d;
      ce_q   <= ce_d;
      pe_q   <= pe_d;
      pg_q   <= pg_d;
      flt_q  <= flt_d;
      pev_q  <= pev_d;
      gev_q  <= gev_d;
      for (int i = 0; i < NCH; i++) begin
        st_q[i]   <= st_d[i];
        cool_q[i] <= cool_d[i];
        res_q[i]  <= res_d[i];
        pol_q[i]  <= pol_d[i];
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = mode_q;
      A_EN:    rd_data = {ce_q, de_q};
      A_EVT:   rd_data = {gev_q, pev_q};
      A_STAT:  rd_data = {pg_q, pe_q};
      A_FLT:   rd_data = {4'h0, flt_q};
      4'd6:    rd_data = res_q[0];
      4'd7:    rd_data = res_q[1];
      4'd8:    rd_data = res_q[2];
      4'd9:    rd_data = res_q[3];
      4'd10:   rd_data = pol_q[0];
      4'd11:   rd_data = pol_q[1];
      4'd12:   rd_data = pol_q[2];
      4'd13:   rd_data = pol_q[3];
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: tb/sim_pse_mode_ctrl.sv
`timescale 1ns/10ps
module sim_pse_mode_ctrl;
  localparam int COOL = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [3:0]  det_done = '0, det_ok = '0, cls_done = '0;
  logic [11:0] cls_code = '0;
  logic [3:0]  pg_in = 4'hF, pwr_fault = '0;
  logic [3:0]  det_req, cls_req, pwr_en;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { int sel; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  event kick, mon_done;

  pse_mode_ctrl #(.COOL_CYCLES(COOL)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .det_done(det_done), .det_ok(det_ok),
    .cls_done(cls_done), .cls_code(cls_code), .pg_in(pg_in), .pwr_fault(pwr_fault),
    .det_req(det_req), .cls_req(cls_req), .pwr_en(pwr_en));

  always #10 clk = ~clk;

  // monitor: pops expected items and compares them with the design outputs
  initial forever begin
    @(kick);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q[0];
      if (it.sel < 16) rd_addr = it.sel[3:0];
      #0.1;
      case (it.sel)
        16:      act = {4'h0, det_req};
        17:      act = {4'h0, cls_req};
        18:      act = {4'h0, pwr_en};
        default: act = rd_data;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
      void'(q.pop_front());
    end
    ->mon_done;
  end

  task automatic chk(input int sel, input logic [7:0] exp, input string tag);
    q.push_back('{sel, exp, tag});
    ->kick;
    @(mon_done);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic det(input int i, input bit ok);
    @(negedge clk); det_done[i] = 1'b1; det_ok[i] = ok;
    @(negedge clk); det_done[i] = 1'b0; det_ok[i] = 1'b0;
  endtask

  task automatic cls(input int i, input logic [2:0] code);
    @(negedge clk); cls_done[i] = 1'b1; cls_code[3*i +: 3] = code;
    @(negedge clk); cls_done[i] = 1'b0;
  endtask

  task automatic flt(input int i);
    @(negedge clk); pwr_fault[i] = 1'b1;
    @(negedge clk); pwr_fault[i] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired before the sequence completed");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(0, 8'h00, "R1 mode reset");
    chk(1, 8'h00, "R2 enables reset");
    chk(3, 8'h00, "R2 events reset");
    chk(4, 8'h00, "R2 status reset");
    chk(10, 8'hFF, "R2 policing reset");
    chk(16, 8'h00, "R2 no request");

    wr(1, 8'hFF);
    chk(1, 8'h00, "R3 enables ignored when off");
    wr(2, 8'h0F);
    chk(18, 8'h00, "R3 power-on ignored when off");
    tick(2);
    chk(16, 8'h00, "R3 no detection when off");

    wr(0, 8'hE4);
    chk(0, 8'hE4, "R1 field layout");

    // manual channel 1
    wr(1, 8'h22);
    tick(1);
    chk(16, 8'h02, "R6 manual detection starts");
    det(1, 1'b1);
    chk(17, 8'h02, "R6 class follows detection");
    chk(16, 8'h00, "R6 single detection");
    chk(1, 8'h20, "R6 detect enable self-clears");
    cls(1, 3'd5);
    chk(7, 8'h1B, "R13 result byte");
    chk(1, 8'h00, "R6 class enable self-clears");
    chk(18, 8'h00, "R6 no automatic power");
    tick(3);
    chk(16, 8'h00, "R6 no repeat");

    wr(2, 8'h02);
    chk(18, 8'h02, "R7 power on at write edge");
    chk(4, 8'h02, "R7 power good not yet");
    tick(1);
    chk(4, 8'h22, "R7 power good one edge later");

    // semi-automatic channel 2
    wr(1, 8'h04);
    tick(1);
    chk(16, 8'h04, "R8 detection starts");
    det(2, 1'b1);
    chk(16, 8'h00, "R8 detection finished");
    tick(1);
    chk(16, 8'h04, "R8 detection repeats");
    wr(1, 8'h44);
    det(2, 1'b1);
    chk(17, 8'h04, "R8 class after valid detection");
    cls(2, 3'd2);
    chk(18, 8'h02, "R8 no automatic power");
    tick(1);
    chk(16, 8'h04, "R8 cycle restarts");
    wr(1, 8'h40);
    det(2, 1'b1);
    tick(3);
    chk(16, 8'h00, "R8 class enable alone idle det");
    chk(17, 8'h00, "R8 class enable alone idle cls");

    // fault and cooldown
    wr(1, 8'h04);
    wr(2, 8'h04);
    chk(18, 8'h06, "R7 semi power on");
    tick(1);
    flt(2);
    chk(18, 8'h02, "R10 fault drops power");
    chk(5, 8'h04, "R10 fault bit latched");
    chk(3, 8'h44, "R5 event flags on drop");
    chk(4, 8'h22, "R10 other channel kept");
    tick(COOL);
    chk(16, 8'h00, "R11 cooldown still blocks");
    tick(1);
    chk(16, 8'h04, "R11 detection after cooldown");
    wr(3, 8'h04);
    chk(3, 8'h40, "R5 write one clears single flag");
    wr(3, 8'h40);
    chk(3, 8'h00, "R5 flags cleared");

    // set wins over clear, then cooldown cancel
    wr(2, 8'h04);
    tick(1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd3; wr_data = 8'h44; pwr_fault[2] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pwr_fault[2] = 1'b0;
    chk(3, 8'h44, "R5 new event beats clear");
    chk(18, 8'h02, "R10 second fault drops power");
    wr(1, 8'h00);
    wr(0, 8'hD4);
    wr(0, 8'hE4);
    wr(1, 8'h04);
    tick(1);
    chk(16, 8'h04, "R12 cooldown cancelled");

    // automatic channel 3
    wr(1, 8'h08);
    det(2, 1'b0);
    tick(3);
    chk(16, 8'h00, "R9 idle with detect enable only");
    wr(1, 8'h88);
    tick(1);
    chk(16, 8'h08, "R9 detection starts");
    det(3, 1'b0);
    chk(16, 8'h00, "R9 invalid signature ends cycle");
    tick(1);
    chk(16, 8'h08, "R9 detection retried");
    det(3, 1'b1);
    chk(17, 8'h08, "R9 class after valid signature");
    cls(3, 3'd3);
    chk(18, 8'h0A, "R9 automatic power on");
    chk(9, 8'h17, "R13 result byte channel 3");
    tick(1);
    chk(4, 8'hAA, "R9 power good follows");

    // off entry
    wr(3, 8'hFF);
    wr(13, 8'h40);
    chk(13, 8'h40, "R4 policing writable");
    wr(11, 8'h33);
    wr(0, 8'h24);
    chk(18, 8'h02, "R4 power removed");
    chk(4, 8'h22, "R4 status cleared");
    chk(3, 8'h88, "R5 events from off entry");
    chk(1, 8'h00, "R4 enables cleared");
    chk(9, 8'h00, "R4 results cleared");
    chk(13, 8'hFF, "R4 policing restored");
    chk(11, 8'h33, "R4 other policing kept");
    chk(7, 8'h1B, "R4 other results kept");
    chk(5, 8'h04, "R10 fault bit before off");
    wr(0, 8'h04);
    chk(5, 8'h00, "R4 fault bit cleared");
    wr(2, 8'h08);
    chk(18, 8'h02, "R3 power-on ignored for off channel");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule